// File: doc/BRIEF.md
# Selectable-Order Fractional Divider Modulator

This block is a digital delta-sigma modulator for a fractional-N frequency synthesizer. It runs on the divided feedback clock and updates once per divider output cycle. On each enabled cycle it takes a 9-bit fractional word and produces a small signed correction. Downstream logic adds that correction to the integer division value. Over many cycles the average division ratio then carries a fractional part with a resolution of 1/512 of one divider step.

A mode input picks one of two structures at run time:

- **Single-accumulator mode.** One 9-bit accumulator gives first-order noise shaping. The output takes only two values.
- **Cascade mode.** Three 9-bit accumulators form a cascade. Each accumulator integrates the residue of the one before it. A differentiating network combines the three carries into third-order shaping, so the output spans several modulus steps.

When the mode changes, every accumulator and every delay register is cleared. No stale residue from one structure leaks into the other.

Top module: `mash_frac_mod`

## Requirements
- R1: While `rst_n` is low, and after it rises, `corr_o` reads 0. The block starts updating only once the synchronised reset has been released, which takes two clock edges.
- R2: With `mode_sel` = 0 (single-accumulator mode), each enabled cycle adds `frac_i` to a 9-bit accumulator. The accumulator keeps the sum modulo 512. `corr_o` becomes the carry out of that sum, which is 0 or 1.
- R3: In single-accumulator mode, starting from a cleared state, the sum of `corr_o` over 512 enabled cycles equals `frac_i` exactly.
- R4: With `mode_sel` = 1 (cascade mode), stage 1 adds `frac_i`, stage 2 adds stage 1's new residue, and stage 3 adds stage 2's new residue, all within the same cycle. Each stage keeps its sum modulo 512 and has a carry c1, c2 or c3. The output is `corr_o` = c1 + c2 − c2' + c3 − 2·c3' + c3''. Here ' marks the value from the previous enabled cycle and '' the value from two enabled cycles earlier.
- R5: `corr_o` is a 4-bit two's-complement value. In cascade mode it always lies in −3..+4.
- R6: A zero `frac_i` applied from a cleared state keeps `corr_o` at a constant 0 in either mode.
- R7: `mode_sel` is sampled on every clock edge, whether or not the block is enabled. On an edge where `mode_sel` differs from the previously sampled value, every accumulator and delay register is cleared and `corr_o` becomes 0. That edge performs no accumulation.
- R8: When `en` is low and the mode is unchanged, the accumulator state and `corr_o` hold. A later enabled cycle resumes from the held state.
- R9: `corr_o` is registered. It changes on the clock edge that samples the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divided feedback clock, one edge per divider output cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Advances the modulator by one step when high |
| mode_sel | input | 1 | 0 = single accumulator, 1 = three-stage cascade |
| frac_i | input | 9 | Fractional control word, unsigned, in units of 1/512 |
| corr_o | output | 4 | Signed two's-complement correction to the integer modulus |

## Verification
A corrupted accumulator or carry shows at `corr_o` on the very next enabled edge. The output depends on every stage's carry through the differentiator, so a wrong stage-2 or stage-3 residue alters the correction within one to three enabled cycles. A lost clear on a mode switch, or a hold that fails while `en` is low, appears as a nonzero output, or as a wrong sequence, on the first cycle after the event. A slow drift in the first-order accumulator shows up as a wrong 512-cycle sum.

// File: rtl/mash_pkg.sv
package mash_pkg;
  typedef enum logic {
    MODE_FIRST = 1'b0,
    MODE_MASH  = 1'b1
  } mod_mode_e;

  localparam int unsigned NUM_STAGES = 3;
endpackage

// File: rtl/frac_rst_sync.sv
module frac_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[DEPTH-1];
endmodule

// File: rtl/frac_acc_stage.sv
module frac_acc_stage #(
  parameter int unsigned ACC_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  input  logic             active,
  input  logic [ACC_W-1:0] addend,
  output logic             carry,
  output logic [ACC_W-1:0] residue,
  output logic [ACC_W-1:0] acc_q
);
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, addend};
    carry   = active & sum[ACC_W];
    residue = active ? sum[ACC_W-1:0] : '0;
  end

  always_comb begin
    acc_d = acc_q;
    if (clr || !active) acc_d = '0;
    else if (step)      acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R2: a carry means the accumulator wrapped and ends lower than it was
  p_carry_wraps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && active && carry) |=> (acc_q < $past(acc_q)));

  // R2: without a carry the accumulator does not decrease
  p_no_carry_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && active && !carry) |=> (acc_q >= $past(acc_q)));

  // R4: a stage that is not active in this mode stays empty
  p_idle_stage_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active) |=> (acc_q == '0));
endmodule

// File: rtl/mash_noise_cancel.sv
module mash_noise_cancel #(
  parameter int unsigned OUT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  logic                    clr,
  input  logic                    mash,
  input  logic                    c1,
  input  logic                    c2,
  input  logic                    c3,
  output logic signed [OUT_W-1:0] y_q
);
  logic c2_d1_q, c3_d1_q, c3_d2_q;
  logic c2_d1_d, c3_d1_d, c3_d2_d;
  logic signed [OUT_W-1:0] y_d;
  logic signed [OUT_W-1:0] cascade_sum;

  function automatic logic signed [OUT_W-1:0] ext(input logic b);
    return $signed({{(OUT_W-1){1'b0}}, b});
  endfunction

  always_comb begin
    cascade_sum = ext(c1) + ext(c2) - ext(c2_d1_q) + ext(c3)
                - (ext(c3_d1_q) <<< 1) + ext(c3_d2_q);
  end

  always_comb begin
    c2_d1_d = c2_d1_q;
    c3_d1_d = c3_d1_q;
    c3_d2_d = c3_d2_q;
    y_d     = y_q;
    if (clr) begin
      c2_d1_d = 1'b0;
      c3_d1_d = 1'b0;
      c3_d2_d = 1'b0;
      y_d     = '0;
    end else if (step) begin
      if (mash) begin
        c2_d1_d = c2;
        c3_d1_d = c3;
        c3_d2_d = c3_d1_q;
        y_d     = cascade_sum;
      end else begin
        c2_d1_d = 1'b0;
        c3_d1_d = 1'b0;
        c3_d2_d = 1'b0;
        y_d     = ext(c1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_d1_q <= 1'b0;
      c3_d1_q <= 1'b0;
      c3_d2_q <= 1'b0;
      y_q     <= '0;
    end else begin
      c2_d1_q <= c2_d1_d;
      c3_d1_q <= c3_d1_d;
      c3_d2_q <= c3_d2_d;
      y_q     <= y_d;
    end
  end

  // R5: cascade output stays in -3..+4
  p_out_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (y_q >= -3) && (y_q <= 4));

  // R2: single-accumulator output is 0 or 1
  p_first_order_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !mash) |=> (y_q == 0 || y_q == 1));

  // R8: output holds while idle
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(y_q));

  // R7: a clear zeroes the output
  p_clear_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (y_q == 0));
endmodule

// File: rtl/mash_frac_mod.sv
module mash_frac_mod
  import mash_pkg::*;
#(
  parameter int unsigned ACC_W = 9,
  parameter int unsigned OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mode_sel,
  input  logic [ACC_W-1:0] frac_i,
  output logic [OUT_W-1:0] corr_o
);
  localparam int unsigned NS = NUM_STAGES;

  logic      rst_sync_n;
  mod_mode_e mode_q, mode_d;
  logic      clr, step;
  logic [NS-1:0]    carry;
  logic [ACC_W-1:0] residue [NS];
  logic [ACC_W-1:0] acc_q   [NS];
  logic signed [OUT_W-1:0] y_q;

  frac_rst_sync #(.DEPTH(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    mode_d = mod_mode_e'(mode_sel);
    clr    = (mode_d != mode_q);
    step   = en & ~clr;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mode_q <= MODE_FIRST;
    else             mode_q <= mode_d;
  end

  for (genvar g = 0; g < NS; g++) begin : g_stage
    logic [ACC_W-1:0] addend;
    logic             active;
    if (g == 0) begin : g_head
      assign addend = frac_i;
      assign active = 1'b1;
    end else begin : g_tail
      assign addend = residue[g-1];
      assign active = (mode_q == MODE_MASH);
    end
    frac_acc_stage #(.ACC_W(ACC_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .step    (step),
      .clr     (clr),
      .active  (active),
      .addend  (addend),
      .carry   (carry[g]),
      .residue (residue[g]),
      .acc_q   (acc_q[g])
    );
  end

  mash_noise_cancel #(.OUT_W(OUT_W)) u_cancel (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .step  (step),
    .clr   (clr),
    .mash  (mode_q == MODE_MASH),
    .c1    (carry[0]),
    .c2    (carry[1]),
    .c3    (carry[2]),
    .y_q   (y_q)
  );

  assign corr_o = y_q;

  // R7: a mode change empties every accumulator
  p_switch_clears_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr |=> (acc_q[0] == '0 && acc_q[1] == '0 && acc_q[2] == '0));

  // R8: accumulators hold while disabled and the mode is unchanged
  p_acc_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!en && !clr) |=> $stable(acc_q[0]));

  // R1: reset state of the output
  p_reset_out_r1: assert property (@(posedge clk) !rst_sync_n |-> corr_o == '0);
endmodule

// File: tb/test_mash_frac_mod.sv
`timescale 1ns/1ps
module test_mash_frac_mod;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic       mode_sel;
  logic [8:0] frac_i;
  logic [3:0] corr_o;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  // model state
  int a1, a2, a3, c2p, c3p, c3pp, ym, mq;

  always #2.5 clk = ~clk;

  mash_frac_mod i_mash_frac_mod (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_sel(mode_sel),
    .frac_i(frac_i), .corr_o(corr_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock step: drive, model, compare after the edge
  task automatic step(input int x, input int m, input bit e, input string req);
    int s1, s2, s3, c1, c2, c3;
    frac_i = 9'(x); mode_sel = m[0]; en = e;
    if (m != mq) begin
      a1 = 0; a2 = 0; a3 = 0; c2p = 0; c3p = 0; c3pp = 0; ym = 0; mq = m;
    end else if (e) begin
      s1 = a1 + x;  c1 = s1 / 512; a1 = s1 % 512;
      if (m == 1) begin
        s2 = a2 + a1; c2 = s2 / 512; a2 = s2 % 512;
        s3 = a3 + a2; c3 = s3 / 512; a3 = s3 % 512;
        ym = c1 + c2 - c2p + c3 - 2 * c3p + c3pp;
        c3pp = c3p; c3p = c3; c2p = c2;
      end else begin
        ym = c1;
      end
    end
    @(posedge clk); #1;
    chk($signed(corr_o) == ym, req, $signed(corr_o), ym);
  endtask

  task automatic clear_into(input int m);
    step(0, 1 - m, 1'b0, "R7");
    step(0, m, 1'b0, "R7");
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_err++; n_checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    int sum;
    rst_n = 1'b0; en = 1'b1; mode_sel = 1'b1; frac_i = 9'd300;
    a1 = 0; a2 = 0; a3 = 0; c2p = 0; c3p = 0; c3pp = 0; ym = 0; mq = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(corr_o == 4'd0, "R1 in reset", corr_o, 0);
    en = 1'b0; mode_sel = 1'b0; frac_i = '0;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(corr_o == 4'd0, "R1 after release", corr_o, 0);

    // R2 R9: single-accumulator sweep over every fractional word
    for (int x = 0; x < 512; x++) begin
      clear_into(0);
      for (int k = 0; k < 20; k++) step(x, 0, 1'b1, (x == 0) ? "R6 first" : "R2");
    end
    // R4 R5: cascade sweep over every fractional word
    for (int x = 0; x < 512; x++) begin
      clear_into(1);
      for (int k = 0; k < 20; k++) begin
        step(x, 1, 1'b1, (x == 0) ? "R6 cascade" : "R4");
        chk($signed(corr_o) >= -3 && $signed(corr_o) <= 4, "R5", $signed(corr_o), 4);
      end
    end
    // R3: exact first-order average over a full period
    for (int v = 0; v < 4; v++) begin
      int xv;
      xv = (v == 0) ? 1 : (v == 1) ? 100 : (v == 2) ? 255 : 511;
      clear_into(0);
      sum = 0;
      for (int k = 0; k < 512; k++) begin
        step(xv, 0, 1'b1, "R3 step");
        sum += $signed(corr_o);
      end
      chk(sum == xv, "R3 sum", sum, xv);
    end
    // R8: hold while disabled, then resume
    clear_into(1);
    for (int k = 0; k < 7; k++) step(333, 1, 1'b1, "R4");
    for (int k = 0; k < 6; k++) step(17 * k, 1, 1'b0, "R8 hold");
    for (int k = 0; k < 10; k++) step(333, 1, 1'b1, "R8 resume");
    // R7: mode switch with enable low still clears
    step(200, 0, 1'b0, "R7 switch idle");
    for (int k = 0; k < 10; k++) step(411, 0, 1'b1, "R7 after");
    // R7: switch with enable high performs no accumulation
    step(411, 1, 1'b1, "R7 switch busy");
    for (int k = 0; k < 10; k++) step(411, 1, 1'b1, "R7 after");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule